// File: doc/BRIEF.md
# Dual-Context Submission Port

This block is the write-only submission register of a command engine. Software loads two 64-bit context descriptors into one register offset as four consecutive 32-bit writes. The second element goes in first, high dword before low dword, and then the first element follows in the same way. The block collects these dwords in a fixed order. When the last dword arrives it checks that element 0 carries its valid bit. It then hands both descriptors to the downstream scheduler as a one-cycle launch pulse. There is no separate go bit: the fourth write itself starts the context load.

A status register at the neighbouring offset can be read. Software uses it as a posting read to flush its submission writes, and it shows the sequence position, a pending launch and the error flag. If the engine reports busy when the fourth write lands, the launch is held and is issued as soon as busy drops. Submission writes that arrive while a launch is held are discarded. Each latched descriptor is also decoded into its flag, addressing-mode and context-ID fields for the scheduler.

The sequencer's named states are `SEQ_E1_HI`, `SEQ_E1_LO`, `SEQ_E0_HI` and `SEQ_E0_LO`. Each accepted submission write advances to the next state, and `SEQ_E0_LO` wraps back to `SEQ_E1_HI`. The launch controller has two states. In `LC_ACCEPT`, a valid final write with busy low fires a launch. With busy high it moves to `LC_HOLD`. With element 0 invalid it sets the error flag and stays in `LC_ACCEPT`. In `LC_HOLD`, the first cycle with busy low fires the launch and returns to `LC_ACCEPT`.

Top module: `ctx_submit_port`

## Requirements
- R1: After reset, no launch is issued, the error flag is 0, both launch descriptors read 0, and a status read returns 0.
- R2: Writes to offset 0x230 fill, in order, element 1 bits 63:32, element 1 bits 31:0, element 0 bits 63:32 and element 0 bits 31:0. At launch, `launch_desc1` and `launch_desc0` hold exactly these values.
- R3: When the fourth write has element 0 bit 0 set and `eng_busy` low, `launch` is high for exactly the one cycle after that write's cycle. The first three writes produce no launch.
- R4: An element 1 written as all zeros (valid bit 0, reported as `el_valid[1]`=0) does not prevent the launch.
- R5: When the fourth write has element 0 bit 0 clear, no launch is issued, `err` becomes 1 in the following cycle and stays 1, and the sequence restarts at element 1 high. `err` returns to 0 in the same cycle as the next launch pulse.
- R6: When `eng_busy` is high at the fourth write, the launch is held and status bit 2 reads 1. `launch` rises in the cycle after the first cycle in which `eng_busy` is sampled low.
- R7: Submission writes that arrive while a launch is held are ignored. The held descriptors are launched unchanged, and the status count stays 0.
- R8: A read at offset 0x234 returns, one cycle later with `bus_rvalid` high, the sequence count (number of dwords accepted so far, 0 to 3) in bits 1:0, the pending flag in bit 2, `err` in bit 3, and zeros elsewhere. A read at 0x230 returns 0. Reads do not change the sequence.
- R9: Each element is decoded as follows: `el_valid` is bit 0, `el_force_pd` is bit 1, `el_force_full` is bit 2, `el_mode` is bits 4:3 (0 advanced, 1 legacy, 2 advanced with A/D bits, 3 legacy 64-bit), `el_coherent` is bit 5, `el_priv` is bit 8, and `el_ctx_id` is bits 51:32.
- R10: `el_fmt_ok` is 1 exactly when bits 63:52, 11:9 and 7:6 are zero and bits 51:32 equal bits 31:12 (the context ID matches the 4 KiB page of the state address).
- R11: Writes to offsets other than 0x230 do not advance the sequence or change any descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset within the engine's register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| eng_busy | input | 1 | Engine cannot accept a new context list |
| launch | output | 1 | One-cycle launch of the context list |
| launch_desc0 | output | 64 | Latched element 0 descriptor |
| launch_desc1 | output | 64 | Latched element 1 descriptor |
| err | output | 1 | Sticky flag: element 0 was invalid at the last submission |
| el_valid | output | 2 | Valid bit per element (bit e = element e) |
| el_force_pd | output | 2 | Forced page-directory restore per element |
| el_force_full | output | 2 | Forced full restore per element |
| el_coherent | output | 2 | L3/LLC coherent per element |
| el_priv | output | 2 | Privileged per element |
| el_mode | output | 4 | Addressing mode, 2 bits per element |
| el_ctx_id | output | 40 | Context ID, 20 bits per element |
| el_fmt_ok | output | 2 | Descriptor well-formed per element |

## Verification
Two events can land on the same clock edge: the release of a held launch, when busy falls, and a new write to the submission register. The bench provokes this by driving a fresh dword in exactly the cycle that busy drops. The launch must carry the held descriptors unchanged, and a status read must then show a count of 0. A second coincidence is the clearing of the sticky error flag, which is judged by seeing `err` fall in the same cycle that `launch` rises. The main sweep runs every combination of addressing mode, the four optional flags and the presence of element 1, with the expected fields computed arithmetically.

// File: rtl/csp_pkg.sv
package csp_pkg;

    localparam int DWORD_W = 32;
    localparam int DESC_W  = 2 * DWORD_W;
    localparam int ID_W    = 20;
    localparam int PAGE_LSB = 12;

    localparam int B_VALID    = 0;
    localparam int B_FORCE_PD = 1;
    localparam int B_FORCE_FL = 2;
    localparam int B_MODE_LO  = 3;
    localparam int B_COHERENT = 5;
    localparam int B_PRIV     = 8;
    localparam int B_ID_LO    = 32;

    typedef enum logic [1:0] {
        MODE_ADV    = 2'd0,
        MODE_LEG    = 2'd1,
        MODE_ADV_AD = 2'd2,
        MODE_LEG64  = 2'd3
    } addr_mode_e;

    typedef struct packed {
        logic             valid;
        logic             force_pd;
        logic             force_full;
        logic             coherent;
        logic             priv;
        addr_mode_e       mode;
        logic [ID_W-1:0]  ctx_id;
        logic             fmt_ok;
    } desc_fields_t;

    typedef enum logic [1:0] {
        SEQ_E1_HI = 2'd0,
        SEQ_E1_LO = 2'd1,
        SEQ_E0_HI = 2'd2,
        SEQ_E0_LO = 2'd3
    } seq_pos_e;

    typedef enum logic {
        LC_ACCEPT = 1'b0,
        LC_HOLD   = 1'b1
    } lc_state_e;

endpackage

// File: rtl/csp_bus_slave.sv
module csp_bus_slave #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SUB_OFS  = 12'h230,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status_word,
    output logic              sub_wr,
    output logic [DATA_W-1:0] sub_data,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    logic hit_sub;
    logic hit_stat;

    always_comb begin
        hit_sub  = (bus_addr == SUB_OFS);
        hit_stat = (bus_addr == STAT_OFS);
        sub_wr   = bus_wr && hit_sub;
        sub_data = bus_wdata;
    end

    // Read path: registered, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd && hit_stat) begin
                bus_rdata <= status_word;
            end else begin
                bus_rdata <= '0;
            end
        end
    end

    // R8: every read strobe is answered exactly one cycle later
    a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    a_r8_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

endmodule

// File: rtl/csp_dword_seq.sv
module csp_dword_seq
    import csp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               sub_wr,
    input  logic [DWORD_W-1:0] sub_data,
    output logic [DESC_W-1:0]  desc0,
    output logic [DESC_W-1:0]  desc1,
    output seq_pos_e           pos,
    output logic               last_wr,
    output logic               last_valid
);

    seq_pos_e pos_nxt;
    logic     take;

    always_comb begin
        take    = sub_wr && accept;
        pos_nxt = pos;
        if (take) begin
            unique case (pos)
                SEQ_E1_HI: pos_nxt = SEQ_E1_LO;
                SEQ_E1_LO: pos_nxt = SEQ_E0_HI;
                SEQ_E0_HI: pos_nxt = SEQ_E0_LO;
                SEQ_E0_LO: pos_nxt = SEQ_E1_HI;
                default:   pos_nxt = SEQ_E1_HI;
            endcase
        end
        last_wr    = take && (pos == SEQ_E0_LO);
        last_valid = sub_data[B_VALID];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= SEQ_E1_HI;
        end else begin
            pos <= pos_nxt;
        end
    end

    // Dword latches, steered by the current position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc0 <= '0;
            desc1 <= '0;
        end else if (take) begin
            unique case (pos)
                SEQ_E1_HI: desc1[DESC_W-1:DWORD_W] <= sub_data;
                SEQ_E1_LO: desc1[DWORD_W-1:0]      <= sub_data;
                SEQ_E0_HI: desc0[DESC_W-1:DWORD_W] <= sub_data;
                SEQ_E0_LO: desc0[DWORD_W-1:0]      <= sub_data;
                default: ;
            endcase
        end
    end

    // R7: while writes are refused the latched state does not move
    a_r7_frozen_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(desc0) && $stable(desc1) && $stable(pos)));

endmodule

// File: rtl/csp_launch_ctrl.sv
module csp_launch_ctrl
    import csp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic last_wr,
    input  logic last_valid,
    input  logic eng_busy,
    output logic accept,
    output logic launch,
    output logic err,
    output logic pending
);

    lc_state_e state;
    lc_state_e state_nxt;
    logic      fire;
    logic      bad;

    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        bad       = 1'b0;
        unique case (state)
            LC_ACCEPT: begin
                if (last_wr && !last_valid) begin
                    bad = 1'b1;
                end else if (last_wr && eng_busy) begin
                    state_nxt = LC_HOLD;
                end else if (last_wr) begin
                    fire = 1'b1;
                end
            end
            LC_HOLD: begin
                if (!eng_busy) begin
                    fire      = 1'b1;
                    state_nxt = LC_ACCEPT;
                end
            end
            default: state_nxt = LC_ACCEPT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LC_ACCEPT;
        end else begin
            state <= state_nxt;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch <= 1'b0;
            err    <= 1'b0;
        end else begin
            launch <= fire;
            if (fire) begin
                err <= 1'b0;
            end else if (bad) begin
                err <= 1'b1;
            end
        end
    end

    always_comb begin
        accept  = (state == LC_ACCEPT);
        pending = (state == LC_HOLD);
    end

    // R3: a launch lasts one cycle
    a_r3_launch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);
    // R6: no launch while the engine stays busy
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && eng_busy) |=> !launch);
    // R5: an error is never raised together with a launch
    a_r5_error_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !launch);

endmodule

// File: rtl/csp_desc_decode.sv
module csp_desc_decode
    import csp_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output desc_fields_t      fields
);

    logic rsvd_clear;
    logic id_match;

    always_comb begin
        rsvd_clear = (desc[DESC_W-1:B_ID_LO+ID_W] == '0)
                  && (desc[PAGE_LSB-1:B_PRIV+1] == '0)
                  && (desc[B_PRIV-1:B_COHERENT+1] == '0);
        id_match   = (desc[B_ID_LO+ID_W-1:B_ID_LO] == desc[PAGE_LSB+ID_W-1:PAGE_LSB]);

        fields.valid      = desc[B_VALID];
        fields.force_pd   = desc[B_FORCE_PD];
        fields.force_full = desc[B_FORCE_FL];
        fields.coherent   = desc[B_COHERENT];
        fields.priv       = desc[B_PRIV];
        fields.mode       = addr_mode_e'(desc[B_MODE_LO+1:B_MODE_LO]);
        fields.ctx_id     = desc[B_ID_LO+ID_W-1:B_ID_LO];
        fields.fmt_ok     = rsvd_clear && id_match;
    end

endmodule

// File: rtl/ctx_submit_port.sv
module ctx_submit_port
    import csp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] SUB_OFS  = 12'h230,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h234,
    parameter int N_EL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic                 eng_busy,
    output logic                 launch,
    output logic [63:0]          launch_desc0,
    output logic [63:0]          launch_desc1,
    output logic                 err,
    output logic [N_EL-1:0]      el_valid,
    output logic [N_EL-1:0]      el_force_pd,
    output logic [N_EL-1:0]      el_force_full,
    output logic [N_EL-1:0]      el_coherent,
    output logic [N_EL-1:0]      el_priv,
    output logic [2*N_EL-1:0]    el_mode,
    output logic [20*N_EL-1:0]   el_ctx_id,
    output logic [N_EL-1:0]      el_fmt_ok
);

    localparam int STAT_PAD = DWORD_W - 4;

    logic               sub_wr;
    logic [DWORD_W-1:0] sub_data;
    logic [DWORD_W-1:0] status_word;
    logic               accept;
    logic               pending;
    logic               last_wr;
    logic               last_valid;
    seq_pos_e           pos;
    logic [DESC_W-1:0]  desc0;
    logic [DESC_W-1:0]  desc1;
    logic [DESC_W-1:0]  desc_arr [N_EL];
    desc_fields_t       fld [N_EL];

    always_comb begin
        status_word = {{STAT_PAD{1'b0}}, err, pending, pos};
    end

    csp_bus_slave #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DWORD_W),
        .SUB_OFS  (SUB_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .status_word (status_word),
        .sub_wr      (sub_wr),
        .sub_data    (sub_data),
        .bus_rdata   (bus_rdata),
        .bus_rvalid  (bus_rvalid)
    );

    csp_dword_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sub_wr     (sub_wr),
        .sub_data   (sub_data),
        .desc0      (desc0),
        .desc1      (desc1),
        .pos        (pos),
        .last_wr    (last_wr),
        .last_valid (last_valid)
    );

    csp_launch_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_wr    (last_wr),
        .last_valid (last_valid),
        .eng_busy   (eng_busy),
        .accept     (accept),
        .launch     (launch),
        .err        (err),
        .pending    (pending)
    );

    always_comb begin
        desc_arr[0]  = desc0;
        desc_arr[1]  = desc1;
        launch_desc0 = desc0;
        launch_desc1 = desc1;
    end

    for (genvar e = 0; e < N_EL; e++) begin : g_el
        csp_desc_decode u_dec (
            .desc   (desc_arr[e]),
            .fields (fld[e])
        );
        always_comb begin
            el_valid[e]            = fld[e].valid;
            el_force_pd[e]         = fld[e].force_pd;
            el_force_full[e]       = fld[e].force_full;
            el_coherent[e]         = fld[e].coherent;
            el_priv[e]             = fld[e].priv;
            el_mode[2*e +: 2]      = fld[e].mode;
            el_ctx_id[20*e +: 20]  = fld[e].ctx_id;
            el_fmt_ok[e]           = fld[e].fmt_ok;
        end
    end

    // R3: a launch always carries a valid element 0
    a_r3_launch_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> el_valid[0]);
    // R7: while held the sequence sits at its start
    a_r7_hold_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (pos == SEQ_E1_HI));
    // R5: a launch clears the error flag in the same cycle
    a_r5_launch_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !err);

endmodule

// File: tb/sim_ctx_submit_port.sv
`timescale 1ns/1ps
module sim_ctx_submit_port;

    localparam logic [11:0] SUB  = 12'h230;
    localparam logic [11:0] STAT = 12'h234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        eng_busy = 1'b0;
    logic        launch;
    logic [63:0] launch_desc0;
    logic [63:0] launch_desc1;
    logic        err;
    logic [1:0]  el_valid, el_force_pd, el_force_full, el_coherent, el_priv, el_fmt_ok;
    logic [3:0]  el_mode;
    logic [39:0] el_ctx_id;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctx_submit_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .eng_busy(eng_busy), .launch(launch),
        .launch_desc0(launch_desc0), .launch_desc1(launch_desc1), .err(err),
        .el_valid(el_valid), .el_force_pd(el_force_pd), .el_force_full(el_force_full),
        .el_coherent(el_coherent), .el_priv(el_priv), .el_mode(el_mode),
        .el_ctx_id(el_ctx_id), .el_fmt_ok(el_fmt_ok)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdesc(input logic [19:0] page, input logic [1:0] mode,
                                           input logic fpd, input logic ffl, input logic coh,
                                           input logic priv, input logic vld);
        return {12'h000, page, page, 3'b000, priv, 2'b00, coh, mode, ffl, fpd, vld};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
        d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    // First three dwords, launch must stay low after each
    task automatic load3(input logic [63:0] d0, input logic [63:0] d1);
        wr(SUB, d1[63:32]); chk("R3 no launch after write 1", {63'd0, launch}, 64'd0);
        wr(SUB, d1[31:0]);  chk("R3 no launch after write 2", {63'd0, launch}, 64'd0);
        wr(SUB, d0[63:32]); chk("R3 no launch after write 3", {63'd0, launch}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [63:0] d0, d1, h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 launch", {63'd0, launch}, 64'd0);
        chk("R1 err", {63'd0, err}, 64'd0);
        chk("R1 desc0", launch_desc0, 64'd0);
        chk("R1 desc1", launch_desc1, 64'd0);
        rd(STAT, s); chk("R1 status", {32'd0, s}, 64'd0);

        // R2 R3 R9 R10 R4: sweep mode x flags x element1 presence
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 32; f++) begin
                logic [19:0] p0, p1;
                p0 = 20'(m * 32 + f + 1) ^ 20'h5A000;
                p1 = 20'(m * 977 + f * 13 + 7);
                d0 = mkdesc(p0, 2'(m), f[0], f[1], f[2], f[3], 1'b1);
                d1 = f[4] ? mkdesc(p1, 2'(3 - m), f[3], f[2], f[1], f[0], 1'b1) : 64'd0;
                load3(d0, d1);
                wr(SUB, d0[31:0]);
                chk("R3 launch after write 4", {63'd0, launch}, 64'd1);
                chk("R2 desc0", launch_desc0, d0);
                chk("R2 desc1", launch_desc1, d1);
                chk("R4 el_valid", {62'd0, el_valid}, {62'd0, f[4], 1'b1});
                chk("R9 mode", {60'd0, el_mode}, {60'd0, d1[4:3], 2'(m)});
                chk("R9 flags e0", {60'd0, el_force_pd[0], el_force_full[0], el_coherent[0], el_priv[0]},
                    {60'd0, f[0], f[1], f[2], f[3]});
                chk("R9 flags e1", {60'd0, el_force_pd[1], el_force_full[1], el_coherent[1], el_priv[1]},
                    {60'd0, d1[1], d1[2], d1[5], d1[8]});
                chk("R9 ctx id", {24'd0, el_ctx_id}, {24'd0, d1[51:32], p0});
                chk("R10 fmt ok", {62'd0, el_fmt_ok}, 64'd3);
                @(negedge clk);
                chk("R3 launch one cycle", {63'd0, launch}, 64'd0);
            end
        end

        // R10 malformed: id mismatch on e0, reserved bit on e1
        d0 = mkdesc(20'h00123, 2'd1, 0, 0, 1, 1, 1) ^ 64'h0000_0001_0000_0000;
        d1 = mkdesc(20'h00456, 2'd0, 0, 0, 0, 0, 1) | 64'h0000_0000_0000_0040;
        load3(d0, d1); wr(SUB, d0[31:0]);
        chk("R10 fmt bad", {62'd0, el_fmt_ok}, 64'd0);
        chk("R10 launch regardless", {63'd0, launch}, 64'd1);
        @(negedge clk);

        // R8 status count mid-sequence, reads do not disturb
        wr(SUB, 32'h1); rd(STAT, s); chk("R8 count 1", {32'd0, s}, 64'd1);
        wr(SUB, 32'h2); rd(SUB, s);  chk("R8 sub reads zero", {32'd0, s}, 64'd0);
        rd(STAT, s); chk("R8 count 2", {32'd0, s}, 64'd2);
        // R11 foreign offsets
        wr(12'h238, 32'hFFFF_FFFF); wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, s); chk("R11 count unchanged", {32'd0, s}, 64'd2);
        chk("R11 desc1 untouched", launch_desc1, 64'h0000_0001_0000_0002);
        wr(SUB, 32'h0); rd(STAT, s); chk("R8 count 3", {32'd0, s}, 64'd3);

        // R5 invalid element 0 on the fourth write
        wr(SUB, 32'h0000_0F00);
        chk("R5 no launch", {63'd0, launch}, 64'd0);
        chk("R5 err set", {63'd0, err}, 64'd1);
        rd(STAT, s); chk("R5 status err, count 0", {32'd0, s}, 64'h8);
        @(negedge clk); chk("R5 err sticky", {63'd0, err}, 64'd1);

        // R5 next good launch clears err in the launch cycle
        d0 = mkdesc(20'h0ABCD, 2'd2, 1, 0, 0, 1, 1);
        load3(d0, 64'd0);
        chk("R5 err still set", {63'd0, err}, 64'd1);
        wr(SUB, d0[31:0]);
        chk("R5 launch", {63'd0, launch}, 64'd1);
        chk("R5 err cleared with launch", {63'd0, err}, 64'd0);
        @(negedge clk);

        // R6 R7 busy hold, extra writes dropped, write coinciding with release
        h0 = mkdesc(20'h31337, 2'd3, 0, 1, 1, 0, 1);
        d1 = mkdesc(20'h00042, 2'd1, 1, 1, 1, 1, 1);
        eng_busy = 1'b1;
        load3(h0, d1); wr(SUB, h0[31:0]);
        chk("R6 held no launch", {63'd0, launch}, 64'd0);
        rd(STAT, s); chk("R6 pending bit", {32'd0, s}, 64'h4);
        wr(SUB, 32'hAAAA_AAAA); wr(SUB, 32'h5555_5555);
        chk("R6 still held", {63'd0, launch}, 64'd0);
        rd(STAT, s); chk("R7 count frozen", {32'd0, s}, 64'h4);
        // release and write in the same cycle
        eng_busy = 1'b0; bus_wr = 1'b1; bus_addr = SUB; bus_wdata = 32'h1234_5678;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        chk("R6 launch after release", {63'd0, launch}, 64'd1);
        chk("R7 held desc0", launch_desc0, h0);
        chk("R7 held desc1", launch_desc1, d1);
        @(negedge clk);
        chk("R6 one pulse", {63'd0, launch}, 64'd0);
        rd(STAT, s); chk("R7 release write dropped", {32'd0, s}, 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule